// File: doc/BRIEF.md
# Video Prefetch FIFO Access Gate

This block sits between a single-ported frame memory and two clients: a video readout that needs one pixel per pixel strobe during active video, and a CPU that wants occasional reads and writes to the same memory. A prefetcher reads the frame buffer sequentially, at up to one word per memory clock, into a small FIFO. The FIFO is drained once per pixel strobe while active video is shown. This decouples the pixel rate from the memory timing.

A CPU request takes the memory port at once, pausing the prefetch for that cycle, but only if the registered FIFO occupancy is at or above a threshold. The threshold is chosen to cover the pixels drained while one CPU access is in progress. Below the threshold the CPU is stalled and the prefetch keeps filling. During blanking nothing is drained, so the FIFO tops up and every CPU request is served without delay.

A vertical-blanking strobe flushes the FIFO and restarts the prefetch at the frame base. If active video finds the FIFO empty, a background value is shown and a sticky underrun flag is raised.

Top module: `vpg_top`

## Requirements
- R1: After each read it issues, the prefetcher advances its address by one word, starting from the frame base. When the FIFO entries plus the read in flight equal the FIFO depth (default 16), the prefetcher issues no read, so `mem_en` is low whenever no CPU request is granted.
- R2: Each clock edge that samples `pix_ce` high with `blank` low produces a one-cycle `pix_valid` pulse, registered at that edge. The pulse carries the next FIFO word on `pix_out`, in prefetch order. With `blank` high, `pix_valid` stays low and the FIFO is not read.
- R3: While `cpu_req` is high and the registered FIFO count is at least `THRESH` (default 4), `cpu_stall` is low. In that same cycle the memory port carries the CPU access: `mem_en` high, `mem_addr` = `cpu_addr`, `mem_we` = `cpu_we`, `mem_wdata` = `cpu_wdata`.
- R4: While `cpu_req` is high and the registered FIFO count is below `THRESH`, `cpu_stall` is high and the prefetcher keeps reading. Right after a flush, a read request is stalled for exactly 5 cycles.
- R5: A granted CPU read gives a one-cycle `cpu_done` pulse in the next cycle, with `cpu_rdata` holding the memory word. A granted write drives `mem_we` for that one cycle only and gives no `cpu_done` pulse.
- R6: While `blank` is held, the FIFO fills and stays full, and every CPU request is granted with zero stall cycles.
- R7: After the word at `FRAME_BASE + FRAME_WORDS - 1`, the prefetch address wraps to `FRAME_BASE`.
- R8: A `vsync_start` pulse empties the FIFO and discards any prefetch read in flight. The next prefetch read uses `FRAME_BASE`.
- R9: If a pixel is due while the FIFO is empty, `pix_out` shows `BG` with `pix_valid` high, and `underrun` goes high. `underrun` stays high until an `underrun_clr` cycle with no new underrun.
- R10: After reset, `pix_valid`, `cpu_done`, `cpu_stall` (with no request) and `underrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| blank | input | 1 | High outside active video |
| vsync_start | input | 1 | One-cycle pulse at the start of vertical blanking |
| pix_ce | input | 1 | Pixel strobe, one per pixel period |
| underrun_clr | input | 1 | Clears the underrun flag |
| pix_out | output | DW | Pixel data |
| pix_valid | output | 1 | One-cycle pixel qualifier |
| underrun | output | 1 | Sticky underrun flag |
| cpu_req | input | 1 | CPU access request, held until granted |
| cpu_we | input | 1 | CPU write when high |
| cpu_addr | input | AW | CPU word address |
| cpu_wdata | input | DW | CPU write data |
| cpu_stall | output | 1 | Request not granted this cycle |
| cpu_done | output | 1 | Read data valid pulse |
| cpu_rdata | output | DW | CPU read data |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read |

## Verification
The interesting collision is a CPU grant in the same cycle as a pixel pop and a FIFO push from the previous prefetch read. In that cycle the occupancy must net out correctly, and the pixel order must not skip or repeat.

The bench provokes this by issuing CPU reads and writes at fixed offsets while active video drains at one pixel every three clocks. Every word that reaches `pix_out` is matched against a queue of expected frame words. Each grant must show zero stall cycles, and each read must return the shadowed memory value on the `cpu_done` pulse.

// File: rtl/vpg_pkg.sv
package vpg_pkg;
  // Source of the memory read that is in flight
  typedef enum logic [1:0] {
    TAG_NONE = 2'd0,
    TAG_PF   = 2'd1,
    TAG_CPU  = 2'd2
  } rd_tag_e;
endpackage

// File: rtl/vpg_fifo.sv
module vpg_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count
);
  localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);

  logic [DW-1:0] store_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign do_push = push && !flush && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop  && !flush && (cnt_q != '0);

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) store_q[wp_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == LASTP) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == LASTP) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head  = store_q[rp_q];
  assign count = cnt_q;
endmodule

// File: rtl/vpg_addr_gen.sv
module vpg_addr_gen #(
  parameter int AW          = 20,
  parameter int FRAME_BASE  = 0,
  parameter int FRAME_WORDS = 480000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reload,
  input  logic          advance,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] BASE = AW'(FRAME_BASE);
  localparam logic [AW-1:0] LAST = AW'(FRAME_BASE + FRAME_WORDS - 1);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst || reload)  addr_q <= BASE;
    else if (advance)   addr_q <= (addr_q == LAST) ? BASE : addr_q + 1'b1;
  end

  assign addr = addr_q;
endmodule

// File: rtl/vpg_arbiter.sv
module vpg_arbiter
  import vpg_pkg::*;
#(
  parameter int AW     = 20,
  parameter int DW     = 16,
  parameter int DEPTH  = 16,
  parameter int THRESH = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [CW-1:0] fifo_cnt,
  input  logic [AW-1:0] pf_addr,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_stall,
  output logic          cpu_done,
  output logic          pf_issue,
  output logic          pf_arrive,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  localparam logic [CW:0]   FULL_LVL = (CW+1)'(DEPTH);
  localparam logic [CW-1:0] THR      = CW'(THRESH);

  rd_tag_e     tag_q;
  logic        grant;
  logic [CW:0] level;

  assign grant    = cpu_req && (fifo_cnt >= THR);
  assign level    = {1'b0, fifo_cnt} + ((tag_q == TAG_PF) ? (CW+1)'(1) : '0);
  assign pf_issue = !grant && !flush && (level < FULL_LVL);

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q    <= TAG_NONE;
      cpu_done <= 1'b0;
    end else begin
      if (grant && !cpu_we) tag_q <= TAG_CPU;
      else if (pf_issue)    tag_q <= TAG_PF;
      else                  tag_q <= TAG_NONE;
      cpu_done <= (tag_q == TAG_NONE || tag_q == TAG_PF || tag_q == TAG_CPU)
                  && grant && !cpu_we;
    end
  end

  assign pf_arrive = (tag_q == TAG_PF) && !flush;
  assign cpu_stall = cpu_req && !grant;
  assign mem_en    = grant || pf_issue;
  assign mem_we    = grant && cpu_we;
  assign mem_addr  = grant ? cpu_addr : pf_addr;
  assign mem_wdata = cpu_wdata;
endmodule

// File: rtl/vpg_pixel_out.sv
module vpg_pixel_out #(
  parameter int          DW    = 16,
  parameter int          DEPTH = 16,
  parameter logic [DW-1:0] BG  = '0,
  localparam int         CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_ce,
  input  logic          blank,
  input  logic          flush,
  input  logic [CW-1:0] fifo_cnt,
  input  logic [DW-1:0] head,
  input  logic          underrun_clr,
  output logic          pop,
  output logic [DW-1:0] pix_out,
  output logic          pix_valid,
  output logic          underrun
);
  logic due, starve;

  assign due    = pix_ce && !blank;
  assign starve = due && ((fifo_cnt == '0) || flush);
  assign pop    = due && !starve;

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_out   <= BG;
      pix_valid <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      pix_valid <= due;
      if (due) pix_out <= starve ? BG : head;
      if (starve)            underrun <= 1'b1;
      else if (underrun_clr) underrun <= 1'b0;
    end
  end
endmodule

// File: rtl/vpg_top.sv
module vpg_top #(
  parameter int            AW          = 20,
  parameter int            DW          = 16,
  parameter int            DEPTH       = 16,
  parameter int            THRESH      = 4,
  parameter int            FRAME_BASE  = 0,
  parameter int            FRAME_WORDS = 480000,
  parameter logic [DW-1:0] BG          = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          blank,
  input  logic          vsync_start,
  input  logic          pix_ce,
  input  logic          underrun_clr,
  output logic [DW-1:0] pix_out,
  output logic          pix_valid,
  output logic          underrun,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_stall,
  output logic          cpu_done,
  output logic [DW-1:0] cpu_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] fifo_cnt;
  logic [DW-1:0] fifo_head;
  logic [AW-1:0] pf_addr;
  logic          pf_issue, pf_arrive, pop;

  vpg_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(vsync_start),
    .push(pf_arrive), .wdata(mem_rdata), .pop(pop),
    .head(fifo_head), .count(fifo_cnt)
  );

  vpg_addr_gen #(.AW(AW), .FRAME_BASE(FRAME_BASE), .FRAME_WORDS(FRAME_WORDS)) u_addr (
    .clk(clk), .rst(rst), .reload(vsync_start), .advance(pf_issue), .addr(pf_addr)
  );

  vpg_arbiter #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .THRESH(THRESH)) u_arb (
    .clk(clk), .rst(rst), .flush(vsync_start), .fifo_cnt(fifo_cnt), .pf_addr(pf_addr),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_stall(cpu_stall), .cpu_done(cpu_done), .pf_issue(pf_issue), .pf_arrive(pf_arrive),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  vpg_pixel_out #(.DW(DW), .DEPTH(DEPTH), .BG(BG)) u_pix (
    .clk(clk), .rst(rst), .pix_ce(pix_ce), .blank(blank), .flush(vsync_start),
    .fifo_cnt(fifo_cnt), .head(fifo_head), .underrun_clr(underrun_clr),
    .pop(pop), .pix_out(pix_out), .pix_valid(pix_valid), .underrun(underrun)
  );

  assign cpu_rdata = mem_rdata;
endmodule

// File: rtl/vpg_checker.sv
module vpg_checker #(
  parameter int AW     = 20,
  parameter int DEPTH  = 16,
  parameter int THRESH = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_stall,
  input logic          cpu_done,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          pix_ce,
  input logic          blank,
  input logic          pix_valid,
  input logic          underrun,
  input logic          underrun_clr,
  input logic [CW-1:0] fifo_cnt
);
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CW'(DEPTH));

  p_blank_no_pixel_r2: assert property (@(posedge clk) disable iff (rst)
    (blank || !pix_ce) |=> !pix_valid);

  p_grant_owns_port_r3: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_stall) |-> (mem_en && mem_addr == cpu_addr && mem_we == cpu_we));

  p_stall_only_low_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_stall |-> (fifo_cnt < CW'(THRESH)));

  p_read_done_r5: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_stall && !cpu_we) |=> cpu_done);

  p_write_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_stall && cpu_we) |=> !cpu_done);

  p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (underrun && !underrun_clr) |=> underrun);
endmodule

bind vpg_top vpg_checker #(.AW(AW), .DEPTH(DEPTH), .THRESH(THRESH)) u_chk (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_stall(cpu_stall), .cpu_done(cpu_done), .mem_en(mem_en), .mem_we(mem_we),
  .mem_addr(mem_addr), .pix_ce(pix_ce), .blank(blank), .pix_valid(pix_valid),
  .underrun(underrun), .underrun_clr(underrun_clr), .fifo_cnt(fifo_cnt)
);

// File: tb/vpg_top_test.sv
module vpg_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6, DW = 16, DEPTH = 16, THRESH = 4, FW = 48;
  localparam logic [DW-1:0] BGV = 16'h0F0F;

  logic clk = 0, rst = 1;
  logic blank = 1, vsync_start = 0, pix_ce = 0, underrun_clr = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] pix_out, cpu_rdata, mem_wdata, mem_rdata;
  logic pix_valid, underrun, cpu_stall, cpu_done, mem_en, mem_we;
  logic [AW-1:0] mem_addr;

  int checks = 0, fails = 0;
  bit mon_on = 1;
  int exp_addr = 0;
  logic [DW-1:0] pix_q[$];
  logic [DW-1:0] rd_q[$];
  logic [DW-1:0] ram [64];
  logic [DW-1:0] shadow [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  vpg_top #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .THRESH(THRESH), .FRAME_BASE(0),
            .FRAME_WORDS(FW), .BG(BGV)) uut (
    .clk(clk), .rst(rst), .blank(blank), .vsync_start(vsync_start), .pix_ce(pix_ce),
    .underrun_clr(underrun_clr), .pix_out(pix_out), .pix_valid(pix_valid),
    .underrun(underrun), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall), .cpu_done(cpu_done),
    .cpu_rdata(cpu_rdata), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  function automatic logic [DW-1:0] pat(int a);
    return 16'h3C00 ^ DW'(a * 257);
  endfunction

  // synchronous RAM, one cycle read latency
  initial for (int i = 0; i < 64; i++) begin ram[i] = pat(i); shadow[i] = pat(i); end
  always @(posedge clk) begin
    if (mem_en && mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_en && !mem_we) mem_rdata <= ram[mem_addr];
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare produced pixels and read data against queues
  always @(negedge clk) begin
    if (!rst && pix_valid && mon_on) begin
      if (pix_q.size() == 0) chk(0, "R2 unexpected pixel", pix_out, 0);
      else begin
        logic [DW-1:0] e;
        e = pix_q.pop_front();
        chk(pix_out == e, "R2/R7 pixel order", pix_out, e);
      end
    end
    if (!rst && cpu_done) begin
      if (rd_q.size() == 0) chk(0, "R5 unexpected done", cpu_rdata, 0);
      else begin
        logic [DW-1:0] e;
        e = rd_q.pop_front();
        chk(cpu_rdata == e, "R5 read data", cpu_rdata, e);
      end
    end
  end

  task automatic vblank();
    @(negedge clk); vsync_start = 1; blank = 1;
    @(negedge clk); vsync_start = 0;
    exp_addr = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // driver for CPU access; called at a negedge, returns at a negedge
  task automatic cpu_access(bit we, int addr, logic [DW-1:0] d, output int stalls);
    stalls = 0;
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(addr); cpu_wdata = d;
    forever begin
      #1;
      if (!cpu_stall) break;
      stalls++;
      @(negedge clk);
    end
    chk(mem_en && mem_addr == AW'(addr) && mem_we == we, "R3 port carries CPU", mem_addr, addr);
    if (we) shadow[addr] = d; else rd_q.push_back(shadow[addr]);
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
    if (we) chk(!cpu_done, "R5 write gives no done", cpu_done, 0);
  endtask

  // driver for active video: pushes expected pixels then strobes
  task automatic run_active(int n, int gap);
    blank = 0;
    for (int k = 0; k < n; k++) begin
      pix_q.push_back(pat(exp_addr));
      exp_addr = (exp_addr + 1) % FW;
      pix_ce = 1;
      @(negedge clk); pix_ce = 0;
      repeat (gap - 1) @(negedge clk);
    end
    blank = 1;
    @(negedge clk);
    chk(pix_q.size() == 0, "R2 all pixels delivered", pix_q.size(), 0);
  endtask

  initial begin
    int st;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk(pix_valid == 0, "R10 pix_valid reset", pix_valid, 0);
    chk(cpu_done == 0, "R10 cpu_done reset", cpu_done, 0);
    chk(cpu_stall == 0, "R10 stall idle", cpu_stall, 0);
    chk(underrun == 0, "R10 underrun reset", underrun, 0);
    chk(mem_en && !mem_we && mem_addr == 0, "R1 first prefetch at base", mem_addr, 0);

    // R1/R6: blanking fills the FIFO, prefetch stops
    idle(25);
    #1 chk(!mem_en, "R1 prefetch halts when full", mem_en, 0);
    @(negedge clk);
    cpu_access(0, 50, '0, st);
    chk(st == 0, "R6 read in blank no stall", st, 0);
    cpu_access(1, 52, 16'hA55A, st);
    chk(st == 0, "R6 write in blank no stall", st, 0);
    cpu_access(0, 52, '0, st);
    chk(st == 0, "R6 readback no stall", st, 0);

    // R2/R7: active video across the frame wrap
    run_active(60, 3);

    // R8: reload at vertical blanking, then partial frame
    vblank();
    idle(20);
    run_active(20, 3);
    vblank();
    idle(20);
    // simultaneous pixel pops and CPU grants (R3)
    fork
      run_active(30, 3);
      begin
        idle(7);
        cpu_access(0, 55, '0, st);
        chk(st == 0, "R3 grant during active", st, 0);
        idle(5);
        cpu_access(1, 57, 16'h1234, st);
        chk(st == 0, "R3 write during active", st, 0);
        idle(4);
        cpu_access(0, 57, '0, st);
        chk(st == 0, "R3 readback during active", st, 0);
      end
    join

    // R4: stall right after a flush, prefetch continues
    @(negedge clk); vsync_start = 1; blank = 1;
    @(negedge clk); vsync_start = 0; exp_addr = 0;
    cpu_req = 1; cpu_we = 0; cpu_addr = 6'd50; #1;
    chk(cpu_stall == 1, "R4 stall when low", cpu_stall, 1);
    chk(mem_en && !mem_we && mem_addr == 0, "R4/R8 prefetch from base while stalled", mem_addr, 0);
    cpu_req = 0;
    @(negedge clk); vsync_start = 1;
    @(negedge clk); vsync_start = 0;
    cpu_access(0, 50, '0, st);
    chk(st == 5, "R4 stall cycle count", st, 5);
    idle(20);
    run_active(10, 3);

    // R9: underrun on empty FIFO
    mon_on = 0;
    @(negedge clk); vsync_start = 1;
    @(negedge clk); vsync_start = 0; blank = 0; pix_ce = 1;
    @(negedge clk); pix_ce = 0; blank = 1;
    chk(pix_valid && pix_out == BGV, "R9 background on underrun", pix_out, BGV);
    chk(underrun == 1, "R9 underrun set", underrun, 1);
    idle(5);
    chk(underrun == 1, "R9 underrun sticky", underrun, 1);
    underrun_clr = 1;
    @(negedge clk); underrun_clr = 0;
    chk(underrun == 0, "R9 underrun cleared", underrun, 0);
    mon_on = 1;
    vblank();
    idle(20);
    run_active(8, 3);
    chk(underrun == 0, "R9 no underrun when fed", underrun, 0);

    idle(3);
    chk(rd_q.size() == 0, "R5 all reads completed", rd_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule